// File: doc/BRIEF.md
# Programmable PIO strobe sequencer

This block converts one host access, read or write, into a timed cycle on an external peripheral bus. Every cycle passes through three phases in a fixed order: an address setup phase, a strobe phase in which the read or write strobe is driven, and a recovery phase. Each phase length is a programmed clock count. The strobe phase has one count for reads and a separate, narrower count for writes.

The device side can be driven one byte wide or one halfword wide. The two bytes of the data path can be exchanged in both directions. When checking is enabled, read data is checked for odd parity on each active byte lane. A failure sets a sticky error flag and pulses an interrupt. The host holds a request until it sees a one-cycle acknowledge, and read data is then waiting on the host read bus.

Top module: `pio_strobe_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, both strobes, the acknowledge, the interrupt and the parity error flag are all low.
- R2: After a request is accepted, chip select rises with no strobe for max(cfg_setup,1) cycles. A programmed 0 gives one cycle.
- R3: The strobe phase lasts max(cfg_rd_strobe,1) cycles for a read, with only dev_rd high. For a write it lasts max(cfg_wr_strobe,1) cycles, with only dev_wr high. The 4-bit read count and the 3-bit write count are independent.
- R4: Recovery keeps chip select high with no strobe for max(cfg_recov,1) cycles. req_ack is high for exactly one cycle, the first cycle after chip select falls.
- R5: dev_addr and dev_dout keep the values of the accepted request for the whole cycle. Changes to req_addr and req_wdata during the cycle have no effect on them.
- R6: req_rdata takes the formatted device data present in the last strobe cycle of a read and holds it until the next read.
- R7: With cfg_half set, all 16 device data bits are used. With it clear, only byte lane 0 (bits 7:0) carries data, dev_dout bits 15:8 are zero, and device bits 15:8 are ignored on reads.
- R8: With cfg_swap set, the two bytes of the host word are exchanged. A write in byte mode then sends req_wdata[15:8] on lane 0. A read in byte mode returns lane 0 in req_rdata[15:8] with req_rdata[7:0] zero.
- R9: With cfg_par_en set, each active lane (lane 0 always, lane 1 only in halfword mode) must have odd parity over its 8 data bits and its dev_din_par bit (bit i for lane i). A failure sets par_err, which stays set until reset, and pulses par_irq for one cycle, the first recovery cycle. With cfg_par_en clear, parity is ignored.
- R10: A request is accepted only while the sequencer is idle and not acknowledging. A request held through the acknowledge cycle starts its chip select two cycles after the acknowledge is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | 3 | Setup phase clock count |
| cfg_rd_strobe | input | 4 | Read strobe phase clock count |
| cfg_wr_strobe | input | 3 | Write strobe phase clock count |
| cfg_recov | input | 2 | Recovery phase clock count |
| cfg_half | input | 1 | 1 = halfword device accesses, 0 = byte |
| cfg_swap | input | 1 | Exchange the two data bytes |
| cfg_par_en | input | 1 | Enable odd parity check on read data |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Host address |
| req_wdata | input | 16 | Host write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data returned to the host |
| dev_addr | output | 8 | Device address |
| dev_dout | output | 16 | Device write data |
| dev_din | input | 16 | Device read data |
| dev_din_par | input | 2 | Parity bit per device byte lane |
| dev_cs | output | 1 | Device chip select |
| dev_rd | output | 1 | Read strobe |
| dev_wr | output | 1 | Write strobe |
| par_err | output | 1 | Sticky parity error flag |
| par_irq | output | 1 | One-cycle parity interrupt pulse |

## Verification
Two events fall on the same clock edge at the end of a read strobe phase: the read data is captured and the parity verdict is taken. The bench drives the device bus with the inverse of the good data in every strobe cycle except the last. A capture taken one cycle early or late therefore returns wrong data. The bench also injects bad parity bits into that final cycle, checks that the captured word is still correct, and checks that the error and the interrupt appear together in the first recovery cycle. A second overlap is a request held high through the acknowledge cycle. The bench checks that the acknowledge and the acceptance do not both happen in that one cycle, and that the next chip select comes exactly one idle cycle later.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pio_lane_fmt.sv
module pio_lane_fmt #(
    parameter int LANE_W = 8,
    localparam int DW = 2 * LANE_W
) (
    input  logic          half,
    input  logic          swap,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] dev_din,
    output logic [DW-1:0] dev_word,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] word_w;
    logic [DW-1:0] raw_r;

    // host -> device: optional byte exchange, then width select
    assign word_w   = swap ? {host_wdata[LANE_W-1:0], host_wdata[DW-1:LANE_W]} : host_wdata;
    assign dev_word = half ? word_w : {{LANE_W{1'b0}}, word_w[LANE_W-1:0]};

    // device -> host: width select, then optional byte exchange
    assign raw_r      = half ? dev_din : {{LANE_W{1'b0}}, dev_din[LANE_W-1:0]};
    assign host_rdata = swap ? {raw_r[LANE_W-1:0], raw_r[DW-1:LANE_W]} : raw_r;
endmodule

// File: rtl/pio_par_chk.sv
module pio_par_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DW = LANES * LANE_W
) (
    input  logic             en,
    input  logic             half,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] par,
    output logic             bad
);
    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic odd_ok;
        assign odd_ok = ^{din[i*LANE_W +: LANE_W], par[i]};
        if (i == 0) begin : g_base
            assign lane_bad[i] = ~odd_ok;
        end else begin : g_upper
            assign lane_bad[i] = half & ~odd_ok;
        end
    end

    assign bad = en & (|lane_bad);
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_seq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANE_W  = 8,
    parameter int SETUP_W = 3,
    parameter int RSTB_W  = 4,
    parameter int WSTB_W  = 3,
    parameter int RCV_W   = 2,
    localparam int LANES  = 2,
    localparam int DW     = LANES * LANE_W,
    localparam int CNT_W  = wmax(wmax(SETUP_W, RSTB_W), wmax(WSTB_W, RCV_W))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [RSTB_W-1:0]  cfg_rd_strobe,
    input  logic [WSTB_W-1:0]  cfg_wr_strobe,
    input  logic [RCV_W-1:0]   cfg_recov,
    input  logic               cfg_half,
    input  logic               cfg_swap,
    input  logic               cfg_par_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_ack,
    output logic [DW-1:0]      req_rdata,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic [DW-1:0]      dev_dout,
    input  logic [DW-1:0]      dev_din,
    input  logic [LANES-1:0]   dev_din_par,
    output logic               dev_cs,
    output logic               dev_rd,
    output logic               dev_wr,
    output logic               par_err,
    output logic               par_irq
);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     dout;
        logic [DW-1:0]     rdata;
        logic              ack;
        logic              perr;
        logic              pirq;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [DW-1:0] fmt_wdata;
    logic [DW-1:0] fmt_rdata;
    logic          par_bad;

    // a programmed 0 behaves as 1: the counter starts at n-1, phase ends at 0
    function automatic logic [CNT_W-1:0] first_cnt(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    pio_lane_fmt #(.LANE_W(LANE_W)) u_fmt (
        .half       (cfg_half),
        .swap       (cfg_swap),
        .host_wdata (req_wdata),
        .dev_din    (dev_din),
        .dev_word   (fmt_wdata),
        .host_rdata (fmt_rdata)
    );

    pio_par_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_par (
        .en   (cfg_par_en),
        .half (cfg_half),
        .din  (dev_din),
        .par  (dev_din_par),
        .bad  (par_bad)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.pirq = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid && !st_q.ack) begin
                    st_d.ph   = PH_SETUP;
                    st_d.cnt  = first_cnt(CNT_W'(cfg_setup));
                    st_d.wr   = req_write;
                    st_d.addr = req_addr;
                    st_d.dout = fmt_wdata;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = st_q.wr ? first_cnt(CNT_W'(cfg_wr_strobe))
                                       : first_cnt(CNT_W'(cfg_rd_strobe));
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RECOV;
                    st_d.cnt = first_cnt(CNT_W'(cfg_recov));
                    if (!st_q.wr) begin
                        st_d.rdata = fmt_rdata;
                        if (par_bad) begin
                            st_d.perr = 1'b1;
                            st_d.pirq = 1'b1;
                        end
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_RECOV: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_IDLE;
                    st_d.ack = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_cs    = (st_q.ph != PH_IDLE);
    assign dev_rd    = (st_q.ph == PH_STROBE) && !st_q.wr;
    assign dev_wr    = (st_q.ph == PH_STROBE) &&  st_q.wr;
    assign dev_addr  = st_q.addr;
    assign dev_dout  = st_q.dout;
    assign req_rdata = st_q.rdata;
    assign req_ack   = st_q.ack;
    assign par_err   = st_q.perr;
    assign par_irq   = st_q.pirq;

    // R3
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> (dev_cs && !(dev_rd && dev_wr)));

    // R4
    ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!dev_cs && $past(dev_cs)));

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cs && $past(dev_cs)) |-> ($stable(dev_addr) && $stable(dev_dout)));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);

    // R9
    irq_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_irq |-> $past(dev_rd));

endmodule

// File: tb/pio_strobe_seq_tb.sv
`timescale 1ns/1ps
module pio_strobe_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_setup = '0;
    logic [3:0]  cfg_rd_strobe = '0;
    logic [2:0]  cfg_wr_strobe = '0;
    logic [1:0]  cfg_recov = '0;
    logic        cfg_half = 1'b0, cfg_swap = 1'b0, cfg_par_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic [7:0]  dev_addr;
    logic [15:0] dev_dout;
    logic [15:0] dev_din = '0;
    logic [1:0]  dev_din_par = '0;
    logic        dev_cs, dev_rd, dev_wr, par_err, par_irq;

    always #10 clk = ~clk;

    pio_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_rd_strobe(cfg_rd_strobe),
        .cfg_wr_strobe(cfg_wr_strobe), .cfg_recov(cfg_recov),
        .cfg_half(cfg_half), .cfg_swap(cfg_swap), .cfg_par_en(cfg_par_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_din(dev_din),
        .dev_din_par(dev_din_par), .dev_cs(dev_cs), .dev_rd(dev_rd),
        .dev_wr(dev_wr), .par_err(par_err), .par_irq(par_irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic logic [1:0] odd_par(input logic [15:0] v);
        return {~^v[15:8], ~^v[7:0]};
    endfunction

    function automatic logic [15:0] exp_rd(input logic h, input logic s, input logic [15:0] g);
        if (h) return s ? {g[7:0], g[15:8]} : g;
        return s ? {g[7:0], 8'h00} : {8'h00, g[7:0]};
    endfunction

    function automatic logic [15:0] exp_wr(input logic h, input logic s, input logic [15:0] w);
        if (h) return s ? {w[7:0], w[15:8]} : w;
        return {8'h00, s ? w[15:8] : w[7:0]};
    endfunction

    // results of one transaction
    int          r_ns, r_np, r_nr, r_irq, r_addr_bad, r_dout_bad, r_wrong_stb;
    logic [15:0] r_rd;
    logic [15:0] g_din;
    logic [1:0]  g_badpar = 2'b00;

    task automatic drive_garbage();
        dev_din     = ~g_din;
        dev_din_par = odd_par(~g_din);
    endtask

    // called at a negedge, idle sequencer; returns at the negedge after the ack cycle
    task automatic run_txn(input logic w, input logic [7:0] a, input logic [15:0] wd, input int exp_p);
        logic [15:0] exp_dout;
        bit done;
        int guard;
        exp_dout = exp_wr(cfg_half, cfg_swap, wd);
        r_ns = 0; r_np = 0; r_nr = 0; r_irq = 0;
        r_addr_bad = 0; r_dout_bad = 0; r_wrong_stb = 0; r_rd = '0;
        drive_garbage();
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        done = 0; guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
            // R5: host side changes during the cycle must not reach the device
            req_addr = ~a; req_wdata = ~wd;
            if (par_irq) r_irq++;
            if (req_ack) begin
                done = 1;
                r_rd = req_rdata;
                req_valid = 1'b0;
            end else if (dev_cs) begin
                if (dev_addr != a) r_addr_bad++;
                if (w && dev_dout != exp_dout) r_dout_bad++;
                if (dev_rd || dev_wr) begin
                    r_np++;
                    if (w ? dev_rd : dev_wr) r_wrong_stb++;
                end else if (r_np == 0) r_ns++;
                else r_nr++;
            end
            if (dev_rd && r_np == exp_p) begin
                dev_din     = g_din;
                dev_din_par = odd_par(g_din) ^ g_badpar;
            end else begin
                drive_garbage();
            end
        end
        @(negedge clk);
        chk(!req_ack && !dev_cs, "R4 ack one cycle", {30'd0, req_ack, dev_cs}, 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({dev_cs, dev_rd, dev_wr, req_ack, par_err, par_irq} == 6'b0, "R1 in reset",
            {26'd0, dev_cs, dev_rd, dev_wr, req_ack, par_err, par_irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dev_cs, dev_rd, dev_wr, req_ack, par_err, par_irq} == 6'b0, "R1 after reset",
            {26'd0, dev_cs, dev_rd, dev_wr, req_ack, par_err, par_irq}, 32'd0);
    endtask

    task automatic check_timing(input string tag, input int es, input int ep, input int er);
        chk(r_ns == es, "R2 setup length", r_ns, es);
        chk(r_np == ep, {"R3 strobe length ", tag}, r_np, ep);
        chk(r_wrong_stb == 0, "R3 strobe kind", r_wrong_stb, 0);
        chk(r_nr == er, "R4 recovery length", r_nr, er);
        chk(r_addr_bad == 0, "R5 address hold", r_addr_bad, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int idx;
        g_din = 16'h5AC3;
        do_reset();

        // R2 R3 R4 R6 R7 R8: read sweep over every setup/strobe/recovery count
        cfg_par_en = 1'b1;
        idx = 0;
        for (int s = 0; s < 8; s++)
            for (int p = 0; p < 16; p++)
                for (int r = 0; r < 4; r++) begin
                    cfg_setup = 3'(s); cfg_rd_strobe = 4'(p); cfg_recov = 2'(r);
                    cfg_wr_strobe = 3'(7 - s);
                    cfg_half = idx[0]; cfg_swap = idx[1];
                    g_din = 16'h5AC3 ^ 16'(idx * 16'h0137);
                    run_txn(1'b0, 8'(idx * 3), 16'h0, eff(p));
                    check_timing("read", eff(s), eff(p), eff(r));
                    chk(r_rd == exp_rd(cfg_half, cfg_swap, g_din), "R6 R7 R8 read capture",
                        r_rd, exp_rd(cfg_half, cfg_swap, g_din));
                    idx++;
                end
        chk(par_err == 1'b0, "R9 no error on good parity", par_err, 0);

        // R3 R5 R7 R8: write sweep, write count independent of read count
        idx = 0;
        for (int s = 0; s < 8; s++)
            for (int p = 0; p < 8; p++)
                for (int r = 0; r < 4; r++) begin
                    logic [15:0] wd;
                    cfg_setup = 3'(s); cfg_wr_strobe = 3'(p); cfg_recov = 2'(r);
                    cfg_rd_strobe = 4'(15 - p);
                    cfg_half = idx[0]; cfg_swap = idx[1];
                    wd = 16'hC35A ^ 16'(idx * 16'h0B1D);
                    run_txn(1'b1, 8'(idx + 5), wd, eff(p));
                    check_timing("write", eff(s), eff(p), eff(r));
                    chk(r_dout_bad == 0, "R7 R8 write data", r_dout_bad, 0);
                    idx++;
                end

        // R10: request held through the ack cycle
        begin
            int guard;
            cfg_setup = 3'd1; cfg_rd_strobe = 4'd1; cfg_recov = 2'd1;
            cfg_half = 1'b1; cfg_swap = 1'b0;
            drive_garbage();
            req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h11;
            guard = 0;
            do begin @(negedge clk); guard++; end while (!req_ack && guard < 50);
            req_addr = 8'h22;
            @(negedge clk);
            chk(dev_cs == 1'b0, "R10 no accept in ack cycle", dev_cs, 0);
            @(negedge clk);
            chk(dev_cs == 1'b1 && dev_addr == 8'h22, "R10 next cycle start", {dev_cs, dev_addr}, {1'b1, 8'h22});
            guard = 0;
            do begin @(negedge clk); guard++; end while (!req_ack && guard < 50);
            req_valid = 1'b0;
            @(negedge clk);
        end

        // R9: parity cases
        cfg_setup = 3'd2; cfg_rd_strobe = 4'd3; cfg_recov = 2'd2;
        g_din = 16'h3C71;

        cfg_half = 1'b0; cfg_par_en = 1'b1; g_badpar = 2'b10;
        run_txn(1'b0, 8'h40, 16'h0, 3);
        chk(par_err == 1'b0 && r_irq == 0, "R9 lane1 ignored in byte mode", {par_err, 8'(r_irq)}, 0);

        cfg_half = 1'b1; cfg_par_en = 1'b0; g_badpar = 2'b11;
        run_txn(1'b0, 8'h41, 16'h0, 3);
        chk(par_err == 1'b0 && r_irq == 0, "R9 check disabled", {par_err, 8'(r_irq)}, 0);

        cfg_half = 1'b1; cfg_par_en = 1'b1; g_badpar = 2'b10;
        run_txn(1'b0, 8'h42, 16'h0, 3);
        chk(par_err == 1'b1, "R9 lane1 error halfword", par_err, 1);
        chk(r_irq == 1, "R9 irq single pulse", r_irq, 1);
        chk(r_rd == g_din, "R6 data kept with parity error", r_rd, g_din);

        g_badpar = 2'b00;
        run_txn(1'b0, 8'h43, 16'h0, 3);
        chk(par_err == 1'b1 && r_irq == 0, "R9 sticky flag", {par_err, 8'(r_irq)}, {1'b1, 8'd0});

        do_reset();
        cfg_half = 1'b0; g_badpar = 2'b01;
        run_txn(1'b0, 8'h44, 16'h0, 3);
        chk(par_err == 1'b1 && r_irq == 1, "R9 lane0 error byte mode", {par_err, 8'(r_irq)}, {1'b1, 8'd1});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule